// File: doc/BRIEF.md
# Dual-Width Add Condition Flags

This block is the flag-producing adder of an integer execution path. It takes a first operand and a second operand that is either a register value or a sign-extended 13-bit immediate. It returns the 64-bit sum and a condition-code byte that describes the same addition at two widths at once. The upper nibble describes the whole 64-bit result. The lower nibble describes only the low 32 bits, as if the operands had been 32-bit values.

The block has no state. The condition-code byte comes with a write strobe that follows the operation-valid input. It also comes with a constant byte mask, which tells the surrounding condition register that only its low eight bits are written. The register file, instruction decode and pipeline staging all stay outside the block.

Top module: `dwadd_flags`

## Requirements
- R1: When `use_imm` is 1, the second operand is `imm` sign-extended from 13 to 64 bits (so `imm` = 13'h1000 gives -4096). When `use_imm` is 0, the second operand is `src_b`, and `imm` has no effect.
- R2: `sum` equals the first operand plus the second operand, modulo 2^64.
- R3: `cc_byte[7]` equals `sum[63]`, and `cc_byte[3]` equals `sum[31]`.
- R4: `cc_byte[6]` is 1 exactly when all 64 bits of `sum` are zero. `cc_byte[2]` is 1 exactly when `sum[31:0]` is zero.
- R5: `cc_byte[5]` (64-bit overflow) is 1 when the two operands' bit 63 values are equal and `sum[63]` differs from them. `cc_byte[1]` applies the same rule to bit 31.
- R6: `cc_byte[4]` is the unsigned carry out of bit 63, and `cc_byte[0]` is the carry out of bit 31. Either carry is 1 when both operand top bits are 1, or when the result top bit is 0 and either operand top bit is 1.
- R7: The byte packs the flags in a fixed order: wide N, Z, V, C in bits 7 to 4, then narrow N, Z, V, C in bits 3 to 0.
- R8: `cc_we` equals `op_valid`, and `cc_mask` is always 8'hFF.
- R9: The narrow flags depend only on the low 32 bits. A carry out of bit 31 sets `cc_byte[0]` without setting `cc_byte[4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_valid | input | 1 | An add operation is presented this cycle |
| use_imm | input | 1 | Selects the immediate as the second operand |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Register second operand |
| imm | input | 13 | Signed immediate second operand |
| sum | output | 64 | 64-bit sum |
| cc_byte | output | 8 | Packed wide and narrow NZVC flags |
| cc_we | output | 1 | Write strobe for the condition byte |
| cc_mask | output | 8 | Byte mask of condition-register bits to write |

## Verification
On every evaluation, the assertions tie the sum to the selected operand, the sign and zero flags to the sum, the wide carry to a 65-bit addition, and the strobe to the valid input. The overflow rule, the narrow carry, and the isolation of the narrow flags from the upper bits only show up under chosen operands. The bench therefore drives the boundary sums (most-positive plus one, all-ones plus one, a low-half-only carry, and the most negative immediate). It also sweeps every immediate value and many random operand pairs against a reference built with wider arithmetic.

// File: rtl/dwadd_pkg.sv
package dwadd_pkg;

    localparam int DATA_W = 64;
    localparam int LO_W   = 32;
    localparam int IMM_W  = 13;
    localparam int CC_W   = 8;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] val);
        return {{(DATA_W-IMM_W){val[IMM_W-1]}}, val};
    endfunction

endpackage

// File: rtl/dwadd_operand_sel.sv
module dwadd_operand_sel
    import dwadd_pkg::*;
(
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] opnd
);
    always_comb begin
        if (use_imm) opnd = sext_imm(imm_val);
        else         opnd = reg_val;
    end
endmodule

// File: rtl/dwadd_flag_slice.sv
module dwadd_flag_slice
    import dwadd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         a_top,
    input  logic         b_top,
    input  logic [W-1:0] res,
    output nzvc_t        flags
);
    logic r_top;
    always_comb begin
        r_top   = res[W-1];
        flags.n = r_top;
        flags.z = (res == '0);
        flags.v = (a_top & b_top & ~r_top) | (~a_top & ~b_top & r_top);
        flags.c = (a_top & b_top) | (~r_top & (a_top | b_top));
    end
endmodule

// File: rtl/dwadd_flags.sv
module dwadd_flags
    import dwadd_pkg::*;
(
    input  logic              op_valid,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] sum,
    output logic [CC_W-1:0]   cc_byte,
    output logic              cc_we,
    output logic [CC_W-1:0]   cc_mask
);
    localparam int NSLICE = 2;

    logic [DATA_W-1:0] opnd_b;
    nzvc_t             slice_f [NSLICE];

    dwadd_operand_sel u_sel (
        .use_imm (use_imm),
        .reg_val (src_b),
        .imm_val (imm),
        .opnd    (opnd_b)
    );

    assign sum = src_a + opnd_b;

    // slice 0 covers the full width, slice 1 the low half
    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        localparam int SW = (g == 0) ? DATA_W : LO_W;
        dwadd_flag_slice #(.W(SW)) u_flag (
            .a_top (src_a[SW-1]),
            .b_top (opnd_b[SW-1]),
            .res   (sum[SW-1:0]),
            .flags (slice_f[g])
        );
    end

    assign cc_byte = {slice_f[0], slice_f[1]};
    assign cc_we   = op_valid;
    assign cc_mask = {CC_W{1'b1}};
endmodule

// File: rtl/dwadd_flags_chk.sv
module dwadd_flags_chk
    import dwadd_pkg::*;
(
    input logic              op_valid,
    input logic              use_imm,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W-1:0]  imm,
    input logic [DATA_W-1:0] sum,
    input logic [CC_W-1:0]   cc_byte,
    input logic              cc_we,
    input logic [CC_W-1:0]   cc_mask
);
    logic [DATA_W-1:0] exp_b;
    logic [DATA_W:0]   wide;

    always_comb begin
        exp_b = use_imm ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} : src_b;
        wide  = {1'b0, src_a} + {1'b0, exp_b};
        // R1 R2
        sum_value_chk: assert (sum == wide[DATA_W-1:0]);
        // R3
        sign_flags_chk: assert (cc_byte[7] == sum[DATA_W-1] && cc_byte[3] == sum[LO_W-1]);
        // R4
        zero_flags_chk: assert (cc_byte[6] == (sum == '0) && cc_byte[2] == (sum[LO_W-1:0] == '0));
        // R6
        wide_carry_chk: assert (cc_byte[4] == wide[DATA_W]);
        // R8
        strobe_mask_chk: assert (cc_we == op_valid && cc_mask == 8'hFF);
    end
endmodule

bind dwadd_flags dwadd_flags_chk u_chk (
    .op_valid (op_valid),
    .use_imm  (use_imm),
    .src_a    (src_a),
    .src_b    (src_b),
    .imm      (imm),
    .sum      (sum),
    .cc_byte  (cc_byte),
    .cc_we    (cc_we),
    .cc_mask  (cc_mask)
);

// File: tb/dwadd_flags_tb.sv
`timescale 1ns/1ps
module dwadd_flags_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        op_valid = 0, use_imm = 0;
    logic [63:0] src_a = '0, src_b = '0;
    logic [12:0] imm = '0;
    logic [63:0] sum;
    logic [7:0]  cc_byte, cc_mask;
    logic        cc_we;
    int total = 0, bad = 0, cyc = 0;
    logic [7:0] last_cc;

    always #2.5 clk = ~clk;

    dwadd_flags u_dut (
        .op_valid(op_valid), .use_imm(use_imm), .src_a(src_a), .src_b(src_b),
        .imm(imm), .sum(sum), .cc_byte(cc_byte), .cc_we(cc_we), .cc_mask(cc_mask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns later (combinational path, no register)
    task automatic apply(input logic v, input logic ui, input logic [63:0] a,
                         input logic [63:0] b, input logic [12:0] im);
        logic [63:0] eb;
        logic [64:0] w;
        logic [32:0] l;
        logic [3:0]  hi, lo;
        @(negedge clk);
        op_valid = v; use_imm = ui; src_a = a; src_b = b; imm = im;
        #1;
        eb = ui ? {{51{im[12]}}, im} : b;
        w  = {1'b0, a} + {1'b0, eb};
        l  = {1'b0, a[31:0]} + {1'b0, eb[31:0]};
        hi = {w[63], w[63:0] == 64'd0, (a[63] == eb[63]) && (w[63] != a[63]), w[64]};
        lo = {l[31], l[31:0] == 32'd0, (a[31] == eb[31]) && (l[31] != a[31]), l[32]};
        chk(ui ? "R1 R2 sum(imm)" : "R2 sum", sum, w[63:0]);
        chk("R3 N", {62'd0, cc_byte[7], cc_byte[3]}, {62'd0, hi[3], lo[3]});
        chk("R4 Z", {62'd0, cc_byte[6], cc_byte[2]}, {62'd0, hi[2], lo[2]});
        chk("R5 V", {62'd0, cc_byte[5], cc_byte[1]}, {62'd0, hi[1], lo[1]});
        chk("R6 C", {62'd0, cc_byte[4], cc_byte[0]}, {62'd0, hi[0], lo[0]});
        chk("R7 packed byte", {56'd0, cc_byte}, {56'd0, hi, lo});
        chk("R8 we/mask", {55'd0, cc_we, cc_mask}, {55'd0, v, 8'hFF});
        last_cc = cc_byte;
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 0;
        // reset/idle state: zero inputs
        apply(0, 0, 64'd0, 64'd0, 13'd0);
        chk("R4 idle Z both", {56'd0, last_cc}, {56'd0, 8'b0100_0100});
        // corner: most positive + 1 -> 64-bit overflow
        apply(1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 13'd0);
        chk("R5 max+1 wide V", {63'd0, last_cc[5]}, 64'd1);
        // corner: all ones + 1 -> zero with carry
        apply(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 13'd0);
        chk("R6 ones+1 byte", {56'd0, last_cc}, {56'd0, 8'b0101_0101});
        // R9: low carry only
        apply(1, 0, 64'h0000_0000_FFFF_FFFF, 64'd1, 13'd0);
        chk("R9 low carry only", {56'd0, last_cc}, {56'd0, 8'b0000_0101});
        // R1: immediate -4096, src_b ignored
        apply(1, 1, 64'd4096, 64'hDEAD_BEEF_0000_1234, 13'h1000);
        chk("R1 imm -4096 sum", sum, 64'd0);
        // R1: register path, imm ignored
        apply(1, 0, 64'd5, 64'd7, 13'h1FFF);
        chk("R1 imm ignored", sum, 64'd12);
        // R5 narrow overflow
        apply(1, 0, 64'h0000_0000_7FFF_FFFF, 64'd1, 13'd0);
        chk("R5 narrow V", {56'd0, last_cc}, {56'd0, 8'b0000_1010});
        // full immediate sweep
        for (int i = 0; i < 8192; i++)
            apply(i[0], 1, {$urandom, $urandom}, {$urandom, $urandom}, i[12:0]);
        // random register sweep with forced top-bit patterns
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            a[63] = i[0]; b[63] = i[1]; a[31] = i[2]; b[31] = i[3];
            apply(i[4], 0, a, b, 13'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule